// File: doc/BRIEF.md
# BCD-Capable Byte ALU with Status Flags

This block is the arithmetic and logic unit of a small accumulator/register processor core. On each cycle in which `in_valid` is high it takes an operation code, a source byte, a destination operand (a byte, or a 16-bit register pair for the pair decrement) and the incoming status bits. One clock later it presents the result, a write-enable for the destination and the updated carry, sign, zero and interrupt-enable status bits. Operand fetch, register-file access and instruction sequencing belong to the surrounding core.

The operation set covers binary add and subtract with and without carry, a subtract-with-borrow of the form d − s − 1 + C, compare, packed-decimal add and subtract with carry, an unsigned byte multiply whose high byte is meant for the A register and whose low byte is meant for B, bitwise logic, move, complement, nibble swap, test, clear, increment, decrement, four rotates and a 16-bit pair decrement. For every subtract-type operation a carry of 1 means that no borrow occurred. The data width, decimal support and the multiplier are parameters.

Top module: `alu8_core`

## Requirements
- R1: Outputs are registered: the result, flags and write-enable for an operation accepted with `in_valid` high appear on the next clock, with `out_valid` high for exactly that cycle. On a cycle after `in_valid` was low, `out_valid` and `wr_en` are 0 and `result` and the flags hold their previous values.
- R2: Code 0 (add) gives d + s and code 1 (add with carry) gives d + s + C. The carry output is the carry out of bit 7.
- R3: Code 2 (subtract) gives d − s and code 3 (subtract with borrow) gives d − s − 1 + C. The carry output is 1 when no borrow occurred.
- R4: Code 4 (compare) presents d − s on `result` and sets carry, sign and zero as subtract does, with `wr_en` 0.
- R5: Code 5 (decimal add) gives the packed-BCD value of d + s + C modulo 100 for valid BCD operands. The carry output is 1 when the decimal sum reaches 100.
- R6: Code 6 (decimal subtract) gives the packed-BCD value of d − s − 1 + C, taken modulo 100. The carry output is 0 when the decimal difference is negative and 1 otherwise.
- R7: Code 7 (multiply) gives the 16-bit unsigned product s × d on `result`, where bits 15:8 are the A byte and bits 7:0 are the B byte. Carry is 0, sign is bit 15, and zero is set when the high byte is 0.
- R8: Codes 8 AND, 9 OR, 10 XOR, 11 move (result s), 12 complement (~d), 13 nibble swap of d, 14 test (result d, `wr_en` 0) and 15 clear (result 0) force carry to 0.
- R9: Code 16 (increment) gives d + 1 with the carry out of bit 7. Code 17 (decrement) gives d − 1 with carry 0 only when d was 0.
- R10: Code 18 rotates left with bit 7 into bit 0, and code 19 rotates left with the old carry into bit 0. Code 20 rotates right with bit 0 into bit 7, and code 21 rotates right with the old carry into bit 7. Each of the four copies the bit shifted out into carry.
- R11: Code 22 (pair decrement) gives the 16-bit value d − 1. Carry is 0 only on the 0000 to FFFF wrap. Sign is bit 15 and zero covers all 16 bits.
- R12: The interrupt-enable output equals the `i_in` value that came with the operation, whatever the operation. Codes 23 to 31 write nothing, give a result of 0 and return carry, sign and zero unchanged.
- R13: For all byte results, sign is bit 7 and zero means bits 7:0 are all 0. The upper result byte is 0. While reset is asserted every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation accepted this cycle |
| op | input | 5 | Operation code (see requirements) |
| src | input | 8 | Source byte |
| dst | input | 16 | Destination operand; bits 7:0 for byte operations, all 16 bits for the pair decrement |
| c_in | input | 1 | Incoming carry |
| n_in | input | 1 | Incoming sign |
| z_in | input | 1 | Incoming zero |
| i_in | input | 1 | Incoming interrupt enable |
| out_valid | output | 1 | Result of the previous cycle's operation is present |
| result | output | 16 | Result value |
| wr_en | output | 1 | Destination should be written |
| c_out | output | 1 | Carry (1 = no borrow for subtracts) |
| n_out | output | 1 | Sign |
| z_out | output | 1 | Zero |
| i_out | output | 1 | Interrupt enable, passed through |

## Verification
Every operation has a latency of one clock: whatever is presented with `in_valid` is due on the outputs after the next rising edge, and nothing else changes them. The bench drives a new operation at each falling edge. At the following falling edge it first compares all outputs against the model's prediction for the operation driven one step earlier, and only then drives the next one. Idle steps expect `out_valid` and `wr_en` low with the previous result and flags held, so no comparison falls in a cycle where a value is still moving.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   localparam int OPW = 5;

   typedef enum logic [OPW-1:0] {
      OP_ADD  = 5'd0,
      OP_ADC  = 5'd1,
      OP_SUB  = 5'd2,
      OP_SBB  = 5'd3,
      OP_CMP  = 5'd4,
      OP_DAC  = 5'd5,
      OP_DSB  = 5'd6,
      OP_MPY  = 5'd7,
      OP_AND  = 5'd8,
      OP_OR   = 5'd9,
      OP_XOR  = 5'd10,
      OP_MOV  = 5'd11,
      OP_INV  = 5'd12,
      OP_SWP  = 5'd13,
      OP_TST  = 5'd14,
      OP_CLR  = 5'd15,
      OP_INC  = 5'd16,
      OP_DEC  = 5'd17,
      OP_RL   = 5'd18,
      OP_RLC  = 5'd19,
      OP_RR   = 5'd20,
      OP_RRC  = 5'd21,
      OP_DECD = 5'd22
   } alu_op_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int W      = 8,
   parameter bit BCD_EN = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   input  logic         dec,
   output logic [W-1:0] sum,
   output logic         cout
);

   localparam int NN = W / 4;

   logic [W:0]   bin_full;
   logic [W-1:0] b_eff;

   assign b_eff    = sub ? ~b : b;
   assign bin_full = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};

   generate
      if (BCD_EN) begin : g_bcd
         logic [W-1:0] dsum;
         logic         dcout;

         always_comb begin
            logic       k;
            logic [4:0] t;
            k    = sub ? ~cin : cin;
            t    = '0;
            dsum = '0;
            for (int g = 0; g < NN; g++) begin
               if (sub) begin
                  t = {1'b0, a[4*g +: 4]} - {1'b0, b[4*g +: 4]} - {4'b0, k};
                  k = t[4];
                  dsum[4*g +: 4] = t[4] ? (t[3:0] + 4'd10) : t[3:0];
               end else begin
                  t = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'b0, k};
                  k = (t > 5'd9);
                  dsum[4*g +: 4] = k ? (t[3:0] + 4'd6) : t[3:0];
               end
            end
            dcout = sub ? ~k : k;
         end

         assign sum  = dec ? dsum  : bin_full[W-1:0];
         assign cout = dec ? dcout : bin_full[W];
      end else begin : g_bin
         assign sum  = bin_full[W-1:0];
         assign cout = bin_full[W];
      end
   endgenerate

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  alu_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] res,
   output logic         cout
);

   localparam int H = W / 2;

   always_comb begin
      res  = a;
      cout = 1'b0;
      case (op)
         OP_AND: res = a & b;
         OP_OR:  res = a | b;
         OP_XOR: res = a ^ b;
         OP_MOV: res = b;
         OP_INV: res = ~a;
         OP_SWP: res = {a[H-1:0], a[W-1:H]};
         OP_TST: res = a;
         OP_CLR: res = '0;
         OP_RL: begin
            res  = {a[W-2:0], a[W-1]};
            cout = a[W-1];
         end
         OP_RLC: begin
            res  = {a[W-2:0], cin};
            cout = a[W-1];
         end
         OP_RR: begin
            res  = {a[0], a[W-1:1]};
            cout = a[0];
         end
         OP_RRC: begin
            res  = {cin, a[W-1:1]};
            cout = a[0];
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
   parameter int W      = 8,
   parameter bit MUL_EN = 1'b1
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] p
);

   localparam int DW = 2 * W;

   generate
      if (MUL_EN) begin : g_mul
         assign p = DW'(a) * DW'(b);
      end else begin : g_nomul
         assign p = '0;
      end
   endgenerate

endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int W      = 8,
   parameter bit BCD_EN = 1'b1,
   parameter bit MUL_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [OPW-1:0]  op,
   input  logic [W-1:0]    src,
   input  logic [2*W-1:0]  dst,
   input  logic            c_in,
   input  logic            n_in,
   input  logic            z_in,
   input  logic            i_in,
   output logic            out_valid,
   output logic [2*W-1:0]  result,
   output logic            wr_en,
   output logic            c_out,
   output logic            n_out,
   output logic            z_out,
   output logic            i_out
);

   localparam int DW = 2 * W;

   generate
      if ((W % 4) != 0 || W < 4) begin : g_bad_width
         $error("alu8_core: W must be a multiple of 4 and at least 4");
      end
   endgenerate

   alu_op_e op_e;
   assign op_e = alu_op_e'(op);

   // adder/subtractor controls
   logic [W-1:0] as_b;
   logic         as_cin, as_sub, as_dec;
   logic [W-1:0] as_sum;
   logic         as_cout;

   always_comb begin
      as_b   = src;
      as_cin = 1'b0;
      as_sub = 1'b0;
      as_dec = 1'b0;
      case (op_e)
         OP_ADC: as_cin = c_in;
         OP_SUB, OP_CMP: begin
            as_sub = 1'b1;
            as_cin = 1'b1;
         end
         OP_SBB: begin
            as_sub = 1'b1;
            as_cin = c_in;
         end
         OP_DAC: begin
            as_dec = 1'b1;
            as_cin = c_in;
         end
         OP_DSB: begin
            as_dec = 1'b1;
            as_sub = 1'b1;
            as_cin = c_in;
         end
         OP_INC: begin
            as_b   = '0;
            as_cin = 1'b1;
         end
         OP_DEC: begin
            as_b   = '0;
            as_sub = 1'b1;
         end
         default: ;
      endcase
   end

   alu8_addsub #(.W(W), .BCD_EN(BCD_EN)) u_addsub (
      .a    (dst[W-1:0]),
      .b    (as_b),
      .cin  (as_cin),
      .sub  (as_sub),
      .dec  (as_dec),
      .sum  (as_sum),
      .cout (as_cout)
   );

   logic [W-1:0] lg_res;
   logic         lg_cout;

   alu8_logic #(.W(W)) u_logic (
      .op   (op_e),
      .a    (dst[W-1:0]),
      .b    (src),
      .cin  (c_in),
      .res  (lg_res),
      .cout (lg_cout)
   );

   logic [DW-1:0] prod;

   alu8_mul #(.W(W), .MUL_EN(MUL_EN)) u_mul (
      .a (src),
      .b (dst[W-1:0]),
      .p (prod)
   );

   logic [DW-1:0] pair_dec;
   assign pair_dec = dst - DW'(1);

   // outcome selection
   logic [DW-1:0] nx_res;
   logic          nx_we, nx_c, nx_n, nx_z, byte_flags;

   always_comb begin
      nx_res     = '0;
      nx_we      = 1'b0;
      nx_c       = c_in;
      nx_n       = n_in;
      nx_z       = z_in;
      byte_flags = 1'b0;
      case (op_e)
         OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_INC, OP_DEC: begin
            nx_res     = DW'(as_sum);
            nx_we      = 1'b1;
            nx_c       = as_cout;
            byte_flags = 1'b1;
         end
         OP_CMP: begin
            nx_res     = DW'(as_sum);
            nx_c       = as_cout;
            byte_flags = 1'b1;
         end
         OP_DAC, OP_DSB: begin
            if (BCD_EN) begin
               nx_res     = DW'(as_sum);
               nx_we      = 1'b1;
               nx_c       = as_cout;
               byte_flags = 1'b1;
            end
         end
         OP_MPY: begin
            if (MUL_EN) begin
               nx_res = prod;
               nx_we  = 1'b1;
               nx_c   = 1'b0;
               nx_n   = prod[DW-1];
               nx_z   = ~|prod[DW-1:W];
            end
         end
         OP_AND, OP_OR, OP_XOR, OP_MOV, OP_INV, OP_SWP, OP_TST, OP_CLR,
         OP_RL, OP_RLC, OP_RR, OP_RRC: begin
            nx_res     = DW'(lg_res);
            nx_we      = (op_e != OP_TST);
            nx_c       = lg_cout;
            byte_flags = 1'b1;
         end
         OP_DECD: begin
            nx_res = pair_dec;
            nx_we  = 1'b1;
            nx_c   = |dst;
            nx_n   = pair_dec[DW-1];
            nx_z   = ~|pair_dec;
         end
         default: ;
      endcase
      if (byte_flags) begin
         nx_n = nx_res[W-1];
         nx_z = ~|nx_res[W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         wr_en     <= 1'b0;
         result    <= '0;
         c_out     <= 1'b0;
         n_out     <= 1'b0;
         z_out     <= 1'b0;
         i_out     <= 1'b0;
      end else begin
         out_valid <= in_valid;
         wr_en     <= in_valid & nx_we;
         if (in_valid) begin
            result <= nx_res;
            c_out  <= nx_c;
            n_out  <= nx_n;
            z_out  <= nx_z;
            i_out  <= i_in;
         end
      end
   end

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
   import alu8_pkg::*;
#(
   parameter int W      = 8,
   parameter bit MUL_EN = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [OPW-1:0]  op,
   input logic [W-1:0]    src,
   input logic [2*W-1:0]  dst,
   input logic            c_in,
   input logic            i_in,
   input logic            out_valid,
   input logic [2*W-1:0]  result,
   input logic            wr_en,
   input logic            c_out,
   input logic            i_out
);

   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (out_valid == $past(in_valid)));

   p_wr_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> out_valid);

   p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_CMP) |=> (out_valid && !wr_en));

   p_mpy_product_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (MUL_EN && in_valid && op == OP_MPY) |=>
         (result == ($past(src) * $past(dst[W-1:0]))));

   p_logic_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op >= OP_AND && op <= OP_CLR) |=> !c_out);

   p_rlc_carry_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_RLC) |=>
         (result[0] == $past(c_in) && c_out == $past(dst[W-1])));

   p_decd_carry_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_DECD) |=> (c_out == ($past(dst) != '0)));

   p_ie_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (i_out == $past(i_in)));

endmodule

bind alu8_core alu8_chk #(.W(W), .MUL_EN(MUL_EN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op        (op),
   .src       (src),
   .dst       (dst),
   .c_in      (c_in),
   .i_in      (i_in),
   .out_valid (out_valid),
   .result    (result),
   .wr_en     (wr_en),
   .c_out     (c_out),
   .i_out     (i_out)
);

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [4:0]  op = '0;
   logic [7:0]  src = '0;
   logic [15:0] dst = '0;
   logic        c_in = 1'b0, n_in = 1'b0, z_in = 1'b0, i_in = 1'b0;
   logic        out_valid, wr_en, c_out, n_out, z_out, i_out;
   logic [15:0] result;

   always #10 clk = ~clk;

   alu8_core dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .src(src), .dst(dst),
      .c_in(c_in), .n_in(n_in), .z_in(z_in), .i_in(i_in),
      .out_valid(out_valid), .result(result), .wr_en(wr_en),
      .c_out(c_out), .n_out(n_out), .z_out(z_out), .i_out(i_out)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 1'b0;

   // expected outputs for the current step
   logic        e_ov = 0, e_we = 0, e_c = 0, e_n = 0, e_z = 0, e_i = 0;
   logic [15:0] e_res = '0;
   string       e_tag = "R13";

   function automatic int bcd2i(logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic logic [7:0] i2bcd(int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   task automatic ref_model(input int o, input logic [7:0] s, input logic [15:0] d,
                            input logic ci, input logic ni, input logic zi,
                            output logic [15:0] r, output logic we, output logic c,
                            output logic n, output logic z, output string tag);
      int t;
      logic [7:0] db;
      bit bytef;
      db = d[7:0];
      r = '0; we = 1'b1; c = 1'b0; n = 1'b0; z = 1'b0; bytef = 1'b1; tag = "R8";
      case (o)
         0:  begin t = int'(db) + int'(s);            r = 16'(t & 255); c = (t > 255); tag = "R2"; end
         1:  begin t = int'(db) + int'(s) + int'(ci); r = 16'(t & 255); c = (t > 255); tag = "R2"; end
         2:  begin t = int'(db) - int'(s);            r = 16'(t & 255); c = (t >= 0);  tag = "R3"; end
         3:  begin t = int'(db) - int'(s) - 1 + int'(ci); r = 16'(t & 255); c = (t >= 0); tag = "R3"; end
         4:  begin t = int'(db) - int'(s); r = 16'(t & 255); c = (t >= 0); we = 1'b0; tag = "R4"; end
         5:  begin
                t = bcd2i(db) + bcd2i(s) + int'(ci);
                c = (t >= 100); r = {8'h00, i2bcd(t % 100)}; tag = "R5";
             end
         6:  begin
                t = bcd2i(db) - bcd2i(s) - 1 + int'(ci);
                if (t < 0) begin t = t + 100; c = 1'b0; end else c = 1'b1;
                r = {8'h00, i2bcd(t)}; tag = "R6";
             end
         7:  begin
                t = int'(db) * int'(s); r = 16'(t); c = 1'b0;
                n = r[15]; z = (r[15:8] == 8'h00); bytef = 1'b0; tag = "R7";
             end
         8:  r = {8'h00, db & s};
         9:  r = {8'h00, db | s};
         10: r = {8'h00, db ^ s};
         11: r = {8'h00, s};
         12: r = {8'h00, ~db};
         13: r = {8'h00, db[3:0], db[7:4]};
         14: begin r = {8'h00, db}; we = 1'b0; end
         15: r = '0;
         16: begin t = int'(db) + 1; r = 16'(t & 255); c = (t > 255); tag = "R9"; end
         17: begin t = int'(db) - 1; r = 16'(t & 255); c = (t >= 0);  tag = "R9"; end
         18: begin r = {8'h00, db[6:0], db[7]}; c = db[7]; tag = "R10"; end
         19: begin r = {8'h00, db[6:0], ci};    c = db[7]; tag = "R10"; end
         20: begin r = {8'h00, db[0], db[7:1]}; c = db[0]; tag = "R10"; end
         21: begin r = {8'h00, ci, db[7:1]};    c = db[0]; tag = "R10"; end
         22: begin
                t = int'(d) - 1; r = 16'(t & 65535); c = (d != 16'h0000);
                n = r[15]; z = (r == 16'h0000); bytef = 1'b0; tag = "R11";
             end
         default: begin
                we = 1'b0; r = '0; c = ci; n = ni; z = zi; bytef = 1'b0; tag = "R12";
             end
      endcase
      if (bytef) begin
         n = r[7];
         z = (r[7:0] == 8'h00);
      end
   endtask

   task automatic compare();
      logic [22:0] act, exp_v;
      act   = {out_valid, result, wr_en, c_out, n_out, z_out, i_out};
      exp_v = {e_ov, e_res, e_we, e_c, e_n, e_z, e_i};
      n_checks++;
      if (act !== exp_v) begin
         n_fail++;
         $display("FAIL %s: got ov=%b res=%h we=%b cnzi=%b%b%b%b, expected ov=%b res=%h we=%b cnzi=%b%b%b%b",
                  e_tag, out_valid, result, wr_en, c_out, n_out, z_out, i_out,
                  e_ov, e_res, e_we, e_c, e_n, e_z, e_i);
      end
   endtask

   // one step: check the outputs due now, then predict and drive the next operation
   task automatic step(input bit v, input int o, input logic [7:0] s, input logic [15:0] d,
                       input logic ci, input logic ni, input logic zi, input logic ii);
      logic [15:0] r;
      logic we, c, n, z;
      string tg;
      @(negedge clk);
      compare();
      if (v) begin
         ref_model(o, s, d, ci, ni, zi, r, we, c, n, z, tg);
         e_ov = 1'b1; e_res = r; e_we = we; e_c = c; e_n = n; e_z = z; e_i = ii; e_tag = tg;
      end else begin
         e_ov = 1'b0; e_we = 1'b0; e_tag = "R1";
      end
      in_valid = v; op = 5'(o); src = s; dst = d;
      c_in = ci; n_in = ni; z_in = zi; i_in = ii;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R13 reset state is checked by the first step
      step(0, 0, 8'h00, 16'h0000, 0, 0, 0, 0);
      // R2 binary add
      step(1, 0, 8'h01, 16'h00FF, 0, 0, 0, 1);
      step(1, 1, 8'h00, 16'h007F, 1, 0, 0, 0);
      step(1, 1, 8'h80, 16'h0080, 0, 0, 0, 1);
      // R3 subtract forms
      step(1, 2, 8'h07, 16'h0005, 0, 0, 0, 0);
      step(1, 2, 8'h07, 16'h0007, 1, 0, 0, 0);
      step(1, 3, 8'h05, 16'h0010, 0, 0, 0, 1);
      step(1, 3, 8'h05, 16'h0010, 1, 0, 0, 1);
      // R4 compare
      step(1, 4, 8'h42, 16'h0042, 0, 0, 0, 0);
      step(1, 4, 8'h43, 16'h0042, 1, 0, 0, 0);
      // R5 decimal add
      step(1, 5, 8'h01, 16'h0099, 0, 0, 0, 0);
      step(1, 5, 8'h38, 16'h0045, 1, 0, 0, 0);
      step(1, 5, 8'h99, 16'h0099, 1, 0, 0, 0);
      // R6 decimal subtract
      step(1, 6, 8'h01, 16'h0000, 1, 0, 0, 0);
      step(1, 6, 8'h25, 16'h0050, 0, 0, 0, 0);
      step(1, 6, 8'h00, 16'h0000, 1, 0, 0, 0);
      // R7 multiply
      step(1, 7, 8'hFF, 16'h00FF, 1, 0, 0, 0);
      step(1, 7, 8'h00, 16'h0037, 1, 0, 0, 0);
      step(1, 7, 8'h10, 16'h0008, 0, 0, 0, 1);
      // R8 logic group with carry in set
      for (int o = 8; o <= 15; o++) step(1, o, 8'h3C, 16'h00A5, 1, 0, 0, 1);
      step(1, 8, 8'h0F, 16'h00F0, 1, 0, 0, 0);
      // R9 increment and decrement boundaries
      step(1, 16, 8'h00, 16'h00FF, 0, 0, 0, 0);
      step(1, 17, 8'h00, 16'h0000, 1, 0, 0, 0);
      step(1, 17, 8'h00, 16'h0001, 0, 0, 0, 0);
      // R10 rotates
      step(1, 18, 8'h00, 16'h0080, 0, 0, 0, 0);
      step(1, 19, 8'h00, 16'h0001, 1, 0, 0, 0);
      step(1, 20, 8'h00, 16'h0001, 0, 0, 0, 0);
      step(1, 21, 8'h00, 16'h0002, 1, 0, 0, 0);
      // R11 pair decrement
      step(1, 22, 8'h00, 16'h0000, 1, 0, 0, 0);
      step(1, 22, 8'h00, 16'h0001, 0, 0, 0, 0);
      step(1, 22, 8'h00, 16'h0100, 0, 0, 0, 0);
      // R12 unused codes keep status, R1 idle holds outputs
      step(1, 25, 8'h12, 16'h0034, 1, 1, 0, 1);
      step(1, 31, 8'h12, 16'h0034, 0, 0, 1, 0);
      step(0, 0, 8'hAA, 16'h5555, 1, 1, 1, 1);
      step(0, 0, 8'h00, 16'h0000, 0, 0, 0, 0);
      // mixed random traffic
      for (int k = 0; k < 3000; k++) begin
         int o;
         logic [7:0] s;
         logic [15:0] d;
         o = int'($urandom_range(0, 31));
         s = 8'($urandom);
         d = 16'($urandom);
         if (o == 5 || o == 6) begin
            s = i2bcd(int'($urandom_range(0, 99)));
            d = {8'h00, i2bcd(int'($urandom_range(0, 99)))};
         end
         step(($urandom_range(0, 7) != 0), o, s, d,
              1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end
      step(0, 0, 8'h00, 16'h0000, 0, 0, 0, 0);
      step(0, 0, 8'h00, 16'h0000, 0, 0, 0, 0);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got running, expected finished");
         finish_run();
      end
   end

endmodule